// File: doc/BRIEF.md
# ChaCha20 Block Keystream Engine

This engine takes a sixteen-word (512-bit) ChaCha state together with a 64-byte data block and returns the data block encrypted or decrypted with that state's keystream. It runs the twenty-round ChaCha permutation over a working copy of the state, one round per clock. Even rounds act on the columns of the 4x4 word matrix. Odd rounds act on its diagonals, which the datapath reaches by rotating rows 1, 2 and 3 left by one, two and three words and then rotating them back. After the last round every working word is added, modulo 2^32, to the matching word of the state that was latched at start. The sum is XORed with the matching data word.

Both data interfaces are valid/ready. A start is accepted on a rising clock edge where `start_valid` and `start_ready` are both high. The state and data are captured at that edge, so the source may change or drop them afterwards. `start_ready` is low while the rounds run and while a finished result waits to be taken. The one exception is a cycle where the result is being taken (`res_valid && res_ready`): in that cycle `start_ready` is high, and a new block can start at the same edge. The sink may hold `res_ready` low for as long as it likes. The result then stays on the port unchanged. Word 12 of the state is the block counter, and the caller supplies it for every block. Word i of a 512-bit port occupies bits [32i+31:32i], with byte 0 in the least significant byte of word 0.

Top module: `chacha_block_engine`

## Requirements
- R1: After reset `start_ready` is 1 and `res_valid` is 0.
- R2: A start is accepted only when `start_valid` and `start_ready` are both high. `start_ready` is 0 while the rounds run, and 0 while a result is held with `res_ready` low.
- R3: `res_valid` rises exactly 20 clock cycles after the edge that accepted the start.
- R4: The result equals ten column-then-diagonal double rounds of the ChaCha quarter round, with rotations 16, 12, 8 and 7.
- R5: Output word i is data word i XOR (final working word i + start state word i), with little-endian bytes: byte b of a port is bits [8b+7:8b].
- R6: Changes on `start_state` and `start_data` after acceptance do not affect the result.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` stays stable.
- R8: In a cycle where the result handshake completes, `start_ready` is 1. A start accepted at that edge begins a new block.
- R9: State words 61707865 3320646e 79622d32 6b206574, the key bytes 00..1f, counter 1 and nonce words 09000000 4a000000 00000000 give keystream word 0 e4e7f110 through word 15 4e3c50a2.
- R10: All additions wrap modulo 2^32. An all-ones state and data give the same result as a 32-bit wrapping model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Start request with state and data |
| start_ready | output | 1 | Engine can accept a start |
| start_state | input | 512 | Sixteen-word ChaCha state, word i at bits [32i+31:32i] |
| start_data | input | 512 | 64-byte data block, little-endian words |
| res_valid | output | 1 | Result block available |
| res_ready | input | 1 | Sink takes the result |
| res_data | output | 512 | Data XOR keystream |

## Verification
Two functions can fall in the same cycle: the result handshake, and acceptance of the next start. The bench provokes this by queueing blocks back to back with `res_ready` held high, so the driver's `start_valid` waits on the very cycle that drains the previous result. It counts these overlapping acceptances. Each block that starts this way must show `res_valid` rising exactly 20 cycles later. Its data must match the scoreboard's reference, which shows that the old result went out whole and the new state was not mixed into it.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W    = 32;
  localparam int ROW_WORDS = 4;
  localparam int NUM_WORDS = ROW_WORDS * ROW_WORDS;
  localparam int BLK_W     = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NUM_WORDS-1:0] blk_t;

  function automatic word_t rotl(word_t v, int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qround.sv
module chacha_qround
  import chacha_pkg::*;
#(
  parameter int unsigned ROT_A = 16,
  parameter int unsigned ROT_B = 12,
  parameter int unsigned ROT_C = 8,
  parameter int unsigned ROT_D = 7
) (
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, a2, b2, c2, d2;

  // four add-xor-rotate steps in a fixed order
  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, ROT_A);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, ROT_B);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, ROT_C);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, ROT_D);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_round.sv
module chacha_round
  import chacha_pkg::*;
(
  input  blk_t st_i,
  input  logic diag_i,
  output blk_t st_o
);
  word_t lane_in  [ROW_WORDS][ROW_WORDS];
  word_t lane_out [ROW_WORDS][ROW_WORDS];

  // lane j, row k: column pick or row k rotated left by k words
  for (genvar j = 0; j < ROW_WORDS; j++) begin : g_lane
    for (genvar k = 0; k < ROW_WORDS; k++) begin : g_pick
      localparam int COL_IDX = ROW_WORDS * k + j;
      localparam int DIA_IDX = ROW_WORDS * k + ((j + k) % ROW_WORDS);
      assign lane_in[j][k] = diag_i ? st_i[DIA_IDX] : st_i[COL_IDX];
    end
    chacha_qround i_qr (
      .a_i(lane_in[j][0]), .b_i(lane_in[j][1]),
      .c_i(lane_in[j][2]), .d_i(lane_in[j][3]),
      .a_o(lane_out[j][0]), .b_o(lane_out[j][1]),
      .c_o(lane_out[j][2]), .d_o(lane_out[j][3])
    );
  end

  // undo the row rotation: word m of row k came from lane (m - k) mod 4
  for (genvar k = 0; k < ROW_WORDS; k++) begin : g_row
    for (genvar m = 0; m < ROW_WORDS; m++) begin : g_word
      localparam int SRC_DIA = (m + ROW_WORDS - k) % ROW_WORDS;
      assign st_o[ROW_WORDS * k + m] = diag_i ? lane_out[SRC_DIA][k] : lane_out[m][k];
    end
  end
endmodule

// File: rtl/chacha_mix.sv
module chacha_mix
  import chacha_pkg::*;
(
  input  blk_t work_i,
  input  blk_t orig_i,
  input  blk_t data_i,
  output blk_t res_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    word_t ks;
    assign ks       = work_i[i] + orig_i[i];
    assign res_o[i] = data_i[i] ^ ks;
  end
endmodule

// File: rtl/chacha_sched.sv
module chacha_sched #(
  parameter int ROUNDS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_valid,
  output logic start_ready,
  input  logic res_ready,
  output logic res_valid,
  output logic load,
  output logic step,
  output logic diag
);
  localparam int CNT_W = (ROUNDS > 2) ? $clog2(ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign start_ready = (!busy && !res_valid) || (res_valid && res_ready);
  assign load        = start_valid && start_ready;
  assign step        = busy;
  assign diag        = cnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      res_valid <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      cnt       <= '0;
      res_valid <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == LAST) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
      end
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_no_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ready);
  assert_no_start_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !start_ready);
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST && !load) |=> (res_valid && !busy));
  assert_valid_from_rounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(busy));
  assert_overlap_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && start_valid) |=> (busy && !res_valid));
endmodule

// File: rtl/chacha_block_engine.sv
module chacha_block_engine
  import chacha_pkg::*;
#(
  parameter int ROUNDS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [BLK_W-1:0] start_state,
  input  logic [BLK_W-1:0] start_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [BLK_W-1:0] res_data
);
  logic load, step, diag;
  blk_t work_q, orig_q, data_q, round_out, mix_out;

  chacha_sched #(.ROUNDS(ROUNDS)) i_sched (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .res_ready(res_ready), .res_valid(res_valid),
    .load(load), .step(step), .diag(diag)
  );

  chacha_round i_round (
    .st_i(work_q), .diag_i(diag), .st_o(round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      orig_q <= '0;
      data_q <= '0;
    end else if (load) begin
      work_q <= start_state;
      orig_q <= start_state;
      data_q <= start_data;
    end else if (step) begin
      work_q <= round_out;
    end
  end

  chacha_mix i_mix (
    .work_i(work_q), .orig_i(orig_q), .data_i(data_q), .res_o(mix_out)
  );
  assign res_data = mix_out;

  assert_inputs_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(orig_q) && $stable(data_q)));
  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: tb/test_chacha_block_engine.sv
`timescale 1ns/1ps
module test_chacha_block_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_valid = 1'b0;
  logic         start_ready;
  logic [511:0] start_state = '0;
  logic [511:0] start_data = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [511:0] res_data;

  chacha_block_engine i_chacha_block_engine (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_state(start_state), .start_data(start_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int same_cnt = 0;
  bit rdy_random = 1'b0;
  bit finished = 1'b0;

  logic [511:0] exp_q[$];
  string        tag_q[$];
  int           acc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    res_ready = rdy_random ? 1'($urandom % 2) : 1'b1;
  end

  function automatic logic [31:0] rl(logic [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [511:0] ref_block(logic [511:0] st, logic [511:0] dt);
    logic [31:0] x [16];
    logic [31:0] s [16];
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin s[i] = st[32*i +: 32]; x[i] = s[i]; end
    for (int it = 0; it < 10; it++) begin
      for (int q = 0; q < 8; q++) begin
        int a, b, c, d;
        if (q < 4) begin a = q; b = 4 + q; c = 8 + q; d = 12 + q; end
        else begin
          a = q - 4; b = 4 + (q - 3) % 4; c = 8 + (q - 2) % 4; d = 12 + (q - 1) % 4;
        end
        x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 16);
        x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 12);
        x[a] = x[a] + x[b]; x[d] = rl(x[d] ^ x[a], 8);
        x[c] = x[c] + x[d]; x[b] = rl(x[b] ^ x[c], 7);
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = dt[32*i +: 32] ^ (x[i] + s[i]);
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes expected item, then scrambles the inputs (R6)
  task automatic send(logic [511:0] st, logic [511:0] dt, logic [511:0] exp, string tag);
    @(negedge clk);
    start_state = st; start_data = dt; start_valid = 1'b1;
    while (!start_ready) @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag); acc_q.push_back(cyc + 1);
    if (res_valid) same_cnt++;
    @(negedge clk);
    start_valid = 1'b0; start_state = rnd512(); start_data = rnd512();
    check(start_ready == 1'b0, "R2 ready low while busy", 512'(start_ready), 512'd0);
  endtask

  // monitor / scoreboard
  bit           prev_valid = 1'b0;
  bit           stall_pend = 1'b0;
  logic [511:0] stall_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid && !prev_valid) begin
        if (acc_q.size() == 0) check(1'b0, "R3 unexpected result", 512'(cyc), 512'd0);
        else check(cyc - acc_q[0] == 20, "R3 latency", 512'(cyc - acc_q[0]), 512'd20);
      end
      if (stall_pend && res_valid)
        check(res_data == stall_data, "R7 hold under back-pressure", res_data, stall_data);
      stall_pend = res_valid && !res_ready;
      stall_data = res_data;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R2 result with empty queue", res_data, '0);
        else begin
          logic [511:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front(); void'(acc_q.pop_front());
          check(res_data == e, t, res_data, e);
        end
      end
      prev_valid = res_valid;
    end
  end

  localparam logic [31:0] ST_W [16] = '{
    32'h61707865, 32'h3320646e, 32'h79622d32, 32'h6b206574,
    32'h03020100, 32'h07060504, 32'h0b0a0908, 32'h0f0e0d0c,
    32'h13121110, 32'h17161514, 32'h1b1a1918, 32'h1f1e1d1c,
    32'h00000001, 32'h09000000, 32'h4a000000, 32'h00000000};
  localparam logic [31:0] KS_W [16] = '{
    32'he4e7f110, 32'h15593bd1, 32'h1fdd0f50, 32'hc47120a3,
    32'hc7f4d1c7, 32'h0368c033, 32'h9aaa2204, 32'h4e6cd4c3,
    32'h466482d2, 32'h09aa9f07, 32'h05d7c214, 32'ha2028bd9,
    32'hd19c12b5, 32'hb94e16de, 32'he883d0cb, 32'h4e3c50a2};

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [511:0] rst, rks, bytes, st, dt;
    for (int i = 0; i < 16; i++) begin rst[32*i +: 32] = ST_W[i]; rks[32*i +: 32] = KS_W[i]; end
    for (int b = 0; b < 64; b++) bytes[8*b +: 8] = 8'(b);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(start_ready == 1'b1, "R1 start_ready after reset", 512'(start_ready), 512'd1);
    check(res_valid == 1'b0, "R1 res_valid after reset", 512'(res_valid), 512'd0);
    check(ref_block(rst, '0) == rks, "R9 reference model sanity", ref_block(rst, '0), rks);

    send(rst, '0, rks, "R9 test vector keystream");
    drain();
    send(rst, bytes, rks ^ bytes, "R5 byte order of data xor");
    drain();
    send({512{1'b1}}, {512{1'b1}}, ref_block({512{1'b1}}, {512{1'b1}}), "R10 wrap all ones");
    drain();

    rdy_random = 1'b1;
    for (int k = 0; k < 8; k++) begin
      st = rnd512(); dt = rnd512();
      send(st, dt, ref_block(st, dt), "R4 R6 random block");
    end
    drain();

    rdy_random = 1'b0;
    for (int k = 0; k < 6; k++) begin
      st = rnd512(); dt = rnd512();
      send(st, dt, ref_block(st, dt), "R8 back-to-back block");
    end
    drain();
    check(exp_q.size() == 0, "R3 all results delivered", 512'(exp_q.size()), 512'd0);
    check(same_cnt > 0, "R8 start accepted in handshake cycle", 512'(same_cnt), 512'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule